// File: doc/BRIEF.md
# Dual-Protocol 4/8-bit Host Bus Interface

This block is the slave side of an asynchronous parallel host bus. It turns host bus cycles into single-cycle write and read strobes for the core logic behind it. A static strap chooses one of two timing styles. In the enable-qualified style, one pin is an enable and a second pin carries the read/write direction. In the split-strobe style, the same two pins act as a separate write strobe and read strobe. A chip-select input gates every transfer. A register-select input steers each transfer to either the command register or the data register.

The bus is either eight bits wide or four bits wide. A data-length flag held inside the block sets the width. The flag is set after reset and is updated whenever the host writes a command byte of the width-setting form. In the narrow mode each byte crosses the upper four data lines as two halves, high half first. A single half pointer is shared by reads and writes. During a read, the block puts either the status word (busy flag and address counter) or the core's read data on the bus, and drives a per-bit output enable for the bidirectional pads. The host strobe pins are asynchronous, so the block passes them through a two-stage synchronizer before it looks for edges.

Top module: `hbi_top`

## Requirements
- R1: During and after reset, wide_mode is 1, the half pointer points at the high half, wr_stb and rd_stb are 0, and db_oe is 0 while cs_n is high.
- R2: With mode_6800=1, a falling edge of e_rd while cs_n=0 and rw_wr=0 produces one wr_stb pulse. The pulse carries wr_sel equal to rs and wr_data equal to db_in as sampled just before the edge.
- R3: With mode_6800=0, a falling edge of rw_wr (write strobe, active high) while cs_n=0 produces one wr_stb pulse that carries rs and db_in.
- R4: Strobe activity while cs_n=1 produces no wr_stb and no rd_stb, and db_oe stays 0.
- R5: db_oe is non-zero only in two cases. With mode_6800=1, it needs cs_n=0, rw_wr=1 and e_rd=1. With mode_6800=0, it needs cs_n=0 and e_rd=0 (read strobe, active low).
- R6: During a read with rs=0 the byte presented is {busy, addr_cnt} (busy in bit 7). With rs=1 the byte presented is rd_data.
- R7: One rd_stb pulse, with rd_sel equal to rs, marks the end of each complete byte read. The end is the falling e_rd with rw_wr=1 in enable mode, or the rising e_rd in split-strobe mode.
- R8: A completed command write (rs=0) whose byte has bits 7:5 equal to 001 loads wide_mode from bit 4 and returns the half pointer to high. Other bytes leave wide_mode unchanged.
- R9: With wide_mode=0, a byte is written as two strobes on db_in[7:4], high half first. Only the second strobe produces wr_stb, with wr_data = {first, second}. db_in[3:0] is ignored.
- R10: With wide_mode=0, the first read strobe shows the high half of the byte on db_out[7:4] and the second shows the low half. db_oe[3:0] stays 0, and only the second strobe produces rd_stb.
- R11: The half pointer is shared. After a single write strobe in narrow mode, the next read strobe shows the low half of its byte and produces rd_stb. The write completes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_6800 | input | 1 | Strap: 1 = enable plus direction, 0 = split strobes |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 0 command/status, 1 data |
| rw_wr | input | 1 | Direction (1 = read) or write strobe (active high) |
| e_rd | input | 1 | Enable (active high) or read strobe (active low) |
| db_in | input | 8 | Data from the bus pads |
| db_out | output | 8 | Data to the bus pads |
| db_oe | output | 8 | Per-bit pad output enable |
| busy | input | 1 | Busy flag from the core |
| addr_cnt | input | 7 | Address counter from the core |
| rd_data | input | 8 | Data register contents from the core |
| wr_stb | output | 1 | One-cycle pulse per completed byte write |
| wr_sel | output | 1 | Register select of the completed write |
| wr_data | output | 8 | Byte of the completed write |
| rd_stb | output | 1 | One-cycle pulse per completed byte read |
| rd_sel | output | 1 | Register select of the completed read |
| wide_mode | output | 1 | Current data length: 1 = eight bits |

## Verification
The bench uses the default two-stage synchronizer. That depth sets the strobe-to-pulse latency, so it also sets how long the bench holds chip select after each strobe. Randomized traffic switches the strap while the bus is idle and flips the width with width-setting command writes. Through these it reaches every combination of protocol, width and register select, including a width change issued in narrow mode. Directed cases cover deselected strobes, ignored low data lines, and a read that picks up the half pointer left behind by a lone write half.

// File: rtl/hbi_pkg.sv
// Package hbi_pkg
// Shared widths, the qualifier record carried beside the strobes, and the
// field positions of the width-setting command byte decoded by this block.
package hbi_pkg;
    localparam int BUS_W   = 8;
    localparam int HALF_W  = BUS_W / 2;
    localparam int ADDR_W  = BUS_W - 1;

    // Width-setting command: bits 7:5 hold the opcode, bit 4 the new width.
    localparam int          FSET_OP_MSB = 7;
    localparam int          FSET_OP_LSB = 5;
    localparam logic [2:0]  FSET_OP     = 3'b001;
    localparam int          FSET_DL_BIT = 4;

    // Bus state sampled alongside the strobes.
    typedef struct packed {
        logic             cs_n;
        logic             rs;
        logic             rw;
        logic [BUS_W-1:0] db;
    } hbi_qual_t;

    localparam int QUAL_W = $bits(hbi_qual_t);
endpackage

// File: rtl/hbi_delay.sv
// Module hbi_delay
// A chain of DEPTH flip-flops used both as a metastability synchronizer and
// as a plain alignment delay. Assumes DEPTH >= 1. Reset loads RST_VAL into
// every stage.
module hbi_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            // Stage i: shift one step along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[i] <= rst_val;
                end else if (i == 0) begin
                    stg[i] <= d;
                end else begin
                    stg[i] <= stg[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/hbi_edge.sv
// Module hbi_edge
// Synchronizes the two strobe pins, detects their edges, and decides from the
// protocol strap whether a write or a read bus cycle has just ended. The chip
// select, register select, direction and data pins are delayed by one stage
// more than the strobes. An edge is therefore judged with the values the bus
// had in the last cycle the strobe was still active.
// Assumes the host holds cs_n, rs, rw_wr and db_in steady around the strobe
// edge for longer than the synchronizer depth, and keeps mode_6800 static
// except while deselected.
module hbi_edge
    import hbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_6800,
    input  logic             cs_n,
    input  logic             rs,
    input  logic             rw_wr,
    input  logic             e_rd,
    input  logic [BUS_W-1:0] db_in,
    output logic             wr_evt,
    output logic             rd_evt,
    output logic             evt_rs,
    output logic [BUS_W-1:0] evt_db
);
    localparam int QUAL_DEPTH = SYNC_STAGES + 1;

    logic [1:0] strb_raw, strb_s, strb_p;
    hbi_qual_t  qual_raw, qual_d;
    logic       e_fall, e_rise, w_fall;
    logic       wr_hit, rd_hit;

    assign strb_raw = {rw_wr, e_rd};
    assign qual_raw = '{cs_n: cs_n, rs: rs, rw: rw_wr, db: db_in};

    hbi_delay #(.WIDTH(2), .DEPTH(SYNC_STAGES)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .rst_val(2'b00), .d(strb_raw), .q(strb_s)
    );

    hbi_delay #(.WIDTH(QUAL_W), .DEPTH(QUAL_DEPTH)) u_qual_dly (
        .clk(clk), .rst_n(rst_n),
        .rst_val({1'b1, {(QUAL_W-1){1'b0}}}),
        .d(qual_raw), .q(qual_d)
    );

    // Previous synchronized strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_p <= 2'b00;
        else        strb_p <= strb_s;
    end

    assign e_fall = strb_p[0] & ~strb_s[0];
    assign e_rise = ~strb_p[0] & strb_s[0];
    assign w_fall = strb_p[1] & ~strb_s[1];

    // Decode the end of a bus cycle per protocol.
    always_comb begin
        if (mode_6800) begin
            wr_hit = e_fall & ~qual_d.cs_n & ~qual_d.rw;
            rd_hit = e_fall & ~qual_d.cs_n &  qual_d.rw;
        end else begin
            wr_hit = w_fall & ~qual_d.cs_n;
            rd_hit = e_rise & ~qual_d.cs_n;
        end
    end

    // Register the event together with its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_evt <= 1'b0;
            rd_evt <= 1'b0;
            evt_rs <= 1'b0;
            evt_db <= '0;
        end else begin
            wr_evt <= wr_hit;
            rd_evt <= rd_hit;
            evt_rs <= qual_d.rs;
            evt_db <= qual_d.db;
        end
    end
endmodule

// File: rtl/hbi_nibble.sv
// Module hbi_nibble
// Owns the data-length flag and the shared half pointer. It assembles
// narrow-mode writes from two upper-line halves and counts narrow-mode reads
// in halves. It issues one strobe per completed byte, and snoops completed
// command writes for the width-setting opcode.
// Assumes wr_evt and rd_evt are never high in the same cycle.
module hbi_nibble
    import hbi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_evt,
    input  logic             rd_evt,
    input  logic             evt_rs,
    input  logic [BUS_W-1:0] evt_db,
    output logic             wr_stb,
    output logic             wr_sel,
    output logic [BUS_W-1:0] wr_data,
    output logic             rd_stb,
    output logic             rd_sel,
    output logic             wide,
    output logic             hi_phase
);
    logic [HALF_W-1:0] hold;
    logic [BUS_W-1:0]  byte_c;
    logic              fset;
    logic              completes;

    // Byte as it stands once this write strobe is taken into account.
    always_comb begin
        byte_c    = wide ? evt_db : {hold, evt_db[BUS_W-1 -: HALF_W]};
        fset      = ~evt_rs && (byte_c[FSET_OP_MSB:FSET_OP_LSB] == FSET_OP);
        completes = wide | ~hi_phase;
    end

    // Half sequencing, byte strobes and the data-length flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide     <= 1'b1;
            hi_phase <= 1'b1;
            hold     <= '0;
            wr_stb   <= 1'b0;
            wr_sel   <= 1'b0;
            wr_data  <= '0;
            rd_stb   <= 1'b0;
            rd_sel   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (wr_evt) begin
                if (completes) begin
                    wr_stb   <= 1'b1;
                    wr_sel   <= evt_rs;
                    wr_data  <= byte_c;
                    hi_phase <= 1'b1;
                    if (fset) wide <= byte_c[FSET_DL_BIT];
                end else begin
                    hold     <= evt_db[BUS_W-1 -: HALF_W];
                    hi_phase <= 1'b0;
                end
            end else if (rd_evt) begin
                if (completes) begin
                    rd_stb   <= 1'b1;
                    rd_sel   <= evt_rs;
                    hi_phase <= 1'b1;
                end else begin
                    hi_phase <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hbi_rdmux.sv
// Module hbi_rdmux
// Chooses the byte presented during a read (status word or data register),
// selects the half in narrow mode, and drives the pad output enables straight
// from the raw bus pins so the pads turn on and off with the host strobe.
// Assumes busy, addr_cnt and rd_data are steady while a read strobe is held.
module hbi_rdmux
    import hbi_pkg::*;
(
    input  logic              mode_6800,
    input  logic              cs_n,
    input  logic              rs,
    input  logic              rw_wr,
    input  logic              e_rd,
    input  logic              wide,
    input  logic              hi_phase,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr_cnt,
    input  logic [BUS_W-1:0]  rd_data,
    output logic [BUS_W-1:0]  db_out,
    output logic [BUS_W-1:0]  db_oe
);
    logic [BUS_W-1:0] src;
    logic             read_on;

    // Read window per protocol.
    always_comb begin
        if (mode_6800) read_on = ~cs_n & rw_wr & e_rd;
        else           read_on = ~cs_n & ~e_rd;
    end

    // Source byte and half selection.
    always_comb begin
        src = rs ? rd_data : {busy, addr_cnt};
        if (wide)
            db_out = src;
        else if (hi_phase)
            db_out = {src[BUS_W-1 -: HALF_W], {HALF_W{1'b0}}};
        else
            db_out = {src[HALF_W-1:0], {HALF_W{1'b0}}};
    end

    // Pad enables: the low lines drive only in wide mode.
    always_comb begin
        db_oe = {{HALF_W{read_on}}, {HALF_W{read_on & wide}}};
    end
endmodule

// File: rtl/hbi_top.sv
// Module hbi_top
// Host bus slave with a strap-selected protocol and a 4/8-bit data path.
// Chain: strobe edge decode, half sequencer, read multiplexer.
// Assumes a synchronous active-low reset and a clock fast enough that every
// host strobe level lasts more than SYNC_STAGES + 1 clock cycles.
module hbi_top
    import hbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_6800,
    input  logic              cs_n,
    input  logic              rs,
    input  logic              rw_wr,
    input  logic              e_rd,
    input  logic [BUS_W-1:0]  db_in,
    output logic [BUS_W-1:0]  db_out,
    output logic [BUS_W-1:0]  db_oe,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr_cnt,
    input  logic [BUS_W-1:0]  rd_data,
    output logic              wr_stb,
    output logic              wr_sel,
    output logic [BUS_W-1:0]  wr_data,
    output logic              rd_stb,
    output logic              rd_sel,
    output logic              wide_mode
);
    logic             wr_evt, rd_evt, evt_rs;
    logic [BUS_W-1:0] evt_db;
    logic             hi_phase;

    hbi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800),
        .cs_n(cs_n), .rs(rs), .rw_wr(rw_wr), .e_rd(e_rd), .db_in(db_in),
        .wr_evt(wr_evt), .rd_evt(rd_evt), .evt_rs(evt_rs), .evt_db(evt_db)
    );

    hbi_nibble u_nib (
        .clk(clk), .rst_n(rst_n),
        .wr_evt(wr_evt), .rd_evt(rd_evt), .evt_rs(evt_rs), .evt_db(evt_db),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_sel(rd_sel),
        .wide(wide_mode), .hi_phase(hi_phase)
    );

    hbi_rdmux u_rmux (
        .mode_6800(mode_6800), .cs_n(cs_n), .rs(rs), .rw_wr(rw_wr),
        .e_rd(e_rd), .wide(wide_mode), .hi_phase(hi_phase),
        .busy(busy), .addr_cnt(addr_cnt), .rd_data(rd_data),
        .db_out(db_out), .db_oe(db_oe)
    );
endmodule

// File: rtl/hbi_checker.sv
// Module hbi_checker
// Temporal properties of hbi_top, attached by the bind below.
module hbi_checker
    import hbi_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             wide_mode,
    input logic             hi_phase,
    input logic [BUS_W-1:0] db_oe,
    input logic             wr_stb,
    input logic             rd_stb
);
    // R1: first cycle out of reset starts wide and at the high half.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (wide_mode && hi_phase && !wr_stb && !rd_stb));

    // R2, R3: a byte write strobe lasts exactly one cycle.
    a_r2_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R7: read and write byte strobes never coincide, and reads pulse once.
    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (!wr_stb ##1 !rd_stb));

    // R4: no pad drives while deselected.
    a_r4_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (db_oe == '0));

    // R10: low lines never drive in narrow mode.
    a_r10_low_lines_off: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (db_oe[HALF_W-1:0] == '0));

    // R8: wide mode never leaves the pointer on the low half.
    a_r8_wide_phase_high: assert property (@(posedge clk) disable iff (!rst_n)
        wide_mode |-> hi_phase);
endmodule

bind hbi_top hbi_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wide_mode(wide_mode),
    .hi_phase(hi_phase), .db_oe(db_oe), .wr_stb(wr_stb), .rd_stb(rd_stb)
);

// File: tb/tb_hbi_top.sv
module tb_hbi_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_6800 = 1'b1;
    logic       cs_n = 1'b1;
    logic       rs = 1'b0;
    logic       rw_wr = 1'b1;
    logic       e_rd = 1'b0;
    logic [7:0] db_in = 8'h00;
    logic [7:0] db_out, db_oe;
    logic       busy = 1'b0;
    logic [6:0] addr_cnt = 7'h00;
    logic [7:0] rd_data = 8'h00;
    logic       wr_stb, wr_sel, rd_stb, rd_sel, wide_mode;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [7:0] last_wr_data = 8'h00;
    logic       last_wr_sel = 1'b0;
    logic       last_rd_sel = 1'b0;
    bit         model_wide = 1'b1;

    always #2.5 clk = ~clk;

    hbi_top dut (
        .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800), .cs_n(cs_n),
        .rs(rs), .rw_wr(rw_wr), .e_rd(e_rd), .db_in(db_in),
        .db_out(db_out), .db_oe(db_oe), .busy(busy), .addr_cnt(addr_cnt),
        .rd_data(rd_data), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .wide_mode(wide_mode)
    );

    // Event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                wr_cnt++;
                last_wr_data = wr_data;
                last_wr_sel  = wr_sel;
            end
            if (rd_stb) begin
                rd_cnt++;
                last_rd_sel = rd_sel;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Switch protocol while deselected and park the idle levels.
    task automatic set_proto(input bit p);
        @(negedge clk);
        cs_n = 1'b1;
        mode_6800 = p;
        if (p) begin rw_wr = 1'b1; e_rd = 1'b0; end
        else   begin rw_wr = 1'b0; e_rd = 1'b1; end
        ticks(8);
    endtask

    // One write strobe; sel selects whether chip select is asserted.
    task automatic wr_cycle(input bit sel, input bit r, input logic [7:0] d);
        @(negedge clk);
        cs_n = ~sel; rs = r; db_in = d;
        if (mode_6800) rw_wr = 1'b0;
        ticks(2);
        if (mode_6800) e_rd = 1'b1; else rw_wr = 1'b1;
        ticks(4);
        if (mode_6800) e_rd = 1'b0; else rw_wr = 1'b0;
        ticks(6);
        cs_n = 1'b1;
        if (mode_6800) rw_wr = 1'b1;
        ticks(2);
    endtask

    // One read strobe; returns bus value and enables seen mid-strobe.
    task automatic rd_cycle(input bit sel, input bit r,
                            output logic [7:0] got, output logic [7:0] oe);
        @(negedge clk);
        cs_n = ~sel; rs = r;
        if (mode_6800) rw_wr = 1'b1;
        ticks(2);
        if (mode_6800) e_rd = 1'b1; else e_rd = 1'b0;
        ticks(3);
        got = db_out; oe = db_oe;
        if (mode_6800) e_rd = 1'b0; else e_rd = 1'b1;
        ticks(6);
        cs_n = 1'b1;
        ticks(2);
    endtask

    // Full byte write at the current width, checked against the model.
    task automatic host_write(input bit r, input logic [7:0] b);
        int c0 = wr_cnt;
        string tg = mode_6800 ? "R2" : "R3";
        if (model_wide) begin
            wr_cycle(1'b1, r, b);
        end else begin
            wr_cycle(1'b1, r, {b[7:4], 4'($urandom)});
            chk(wr_cnt == c0, "R9 no pulse on first half", wr_cnt - c0, 0);
            wr_cycle(1'b1, r, {b[3:0], 4'($urandom)});
            tg = "R9";
        end
        chk(wr_cnt == c0 + 1, tg, wr_cnt - c0, 1);
        chk(last_wr_data == b, tg, last_wr_data, b);
        chk(last_wr_sel == r, tg, last_wr_sel, r);
        if (!r && b[7:5] == 3'b001) model_wide = b[4];
        chk(wide_mode == model_wide, "R8", wide_mode, model_wide);
    endtask

    // Full byte read at the current width, checked against the model.
    task automatic host_read(input bit r, input bit bz, input logic [6:0] ad,
                             input logic [7:0] rdd);
        logic [7:0] exp, g1, o1, g2, o2;
        int c0 = rd_cnt;
        busy = bz; addr_cnt = ad; rd_data = rdd;
        exp = r ? rdd : {bz, ad};
        if (model_wide) begin
            rd_cycle(1'b1, r, g1, o1);
            chk(g1 == exp, "R6", g1, exp);
            chk(o1 == 8'hFF, "R5", o1, 8'hFF);
        end else begin
            rd_cycle(1'b1, r, g1, o1);
            chk(g1[7:4] == exp[7:4], "R10 high half", g1, exp);
            chk(o1 == 8'hF0, "R10 enables", o1, 8'hF0);
            chk(rd_cnt == c0, "R10 no pulse on first half", rd_cnt - c0, 0);
            rd_cycle(1'b1, r, g2, o2);
            chk(g2[7:4] == exp[3:0], "R10 low half", g2, exp);
            chk(o2 == 8'hF0, "R10 enables", o2, 8'hF0);
        end
        chk(rd_cnt == c0 + 1, "R7", rd_cnt - c0, 1);
        chk(last_rd_sel == r, "R7 sel", last_rd_sel, r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] g, o;
        int c0;
        void'($urandom(32'h5EED_0042));
        ticks(3);
        chk(wr_stb == 0 && rd_stb == 0, "R1 strobes in reset", {wr_stb, rd_stb}, 0);
        chk(db_oe == 0, "R1 enables in reset", db_oe, 0);
        @(negedge clk) rst_n = 1'b1;
        ticks(2);
        chk(wide_mode == 1'b1, "R1 wide after reset", wide_mode, 1);

        // R2: enable-qualified writes.
        host_write(1'b1, 8'hA5);
        host_write(1'b0, 8'h80);
        // R6 / R5 / R7 reads in wide mode.
        host_read(1'b0, 1'b1, 7'h4F, 8'h00);
        host_read(1'b1, 1'b0, 7'h00, 8'h3C);

        // R4: deselected traffic.
        c0 = wr_cnt;
        wr_cycle(1'b0, 1'b1, 8'h77);
        chk(wr_cnt == c0, "R4 deselected write", wr_cnt - c0, 0);
        c0 = rd_cnt;
        rd_cycle(1'b0, 1'b1, g, o);
        chk(o == 8'h00, "R4 deselected enables", o, 0);
        chk(rd_cnt == c0, "R4 deselected read", rd_cnt - c0, 0);
        // R5: selected, direction=read, enable low -> no drive.
        @(negedge clk) cs_n = 1'b0; rw_wr = 1'b1;
        ticks(2);
        chk(db_oe == 8'h00, "R5 idle enable", db_oe, 0);
        cs_n = 1'b1;

        // R3: split strobes.
        set_proto(1'b0);
        host_write(1'b1, 8'h5A);
        host_read(1'b1, 1'b0, 7'h11, 8'hC3);
        c0 = wr_cnt;
        wr_cycle(1'b0, 1'b0, 8'h20);
        chk(wr_cnt == c0 && wide_mode == 1'b1, "R4 deselected fset", wide_mode, 1);

        // R8: non-matching command keeps width; matching one narrows.
        host_write(1'b0, 8'h40);
        host_write(1'b0, 8'h2F);
        chk(wide_mode == 1'b0, "R8 narrow", wide_mode, 0);
        // R9 / R10 narrow transfers.
        host_write(1'b1, 8'h96);
        host_read(1'b0, 1'b1, 7'h2A, 8'h00);
        host_read(1'b1, 1'b0, 7'h00, 8'hE1);

        // R11: lone high half written, next read shows low half.
        set_proto(1'b1);
        c0 = wr_cnt;
        wr_cycle(1'b1, 1'b1, 8'hB0);
        chk(wr_cnt == c0, "R11 no byte", wr_cnt - c0, 0);
        rd_data = 8'h6D;
        c0 = rd_cnt;
        rd_cycle(1'b1, 1'b1, g, o);
        chk(g[7:4] == 4'hD, "R11 low half shown", g, 8'hD0);
        chk(rd_cnt == c0 + 1, "R11 read completes", rd_cnt - c0, 1);
        host_write(1'b1, 8'h3E);

        // R8: widen from narrow mode.
        host_write(1'b0, 8'h30);
        chk(wide_mode == 1'b1, "R8 widen", wide_mode, 1);

        // Random mix.
        for (int i = 0; i < 150; i++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) set_proto(1'($urandom));
            else if (op == 1) host_write(1'b0, {3'b001, 1'($urandom), 4'($urandom)});
            else if (op < 6) host_write(1'($urandom), 8'($urandom));
            else host_read(1'($urandom), 1'($urandom), 7'($urandom), 8'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule